// File: doc/BRIEF.md
# Parallel NOR Flash Command Controller

This block is a clocked model of the command front end and embedded write engine of a byte-wide NOR flash with uniform 4 KB sectors. It samples the active-low chip-enable, output-enable and write-enable strobes, together with the address and data buses, on every clock. It recognises the guarded multi-write unlock sequences for byte program, sector erase and chip erase. A recognised command starts a timed internal operation on a small parameterised storage array.

While an operation is running, the array cannot be read. A read instead returns a status byte. Bit 7 of that byte is the inverse of bit 7 of the value being written. Bit 6 flips after each completed read. Once the operation ends, reads return array contents again.

The bus is a strobe bus and has no back-pressure. The host learns that the block is busy only by polling with reads, and any write issued during that time is dropped. The read data is valid while `dq_oe` is high. `dq_oe` models the enable of the tri-state output driver.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: A bus write is a stretch of sampled clocks with chip-enable low, write-enable low and output-enable high. The address is captured in the first clock of that stretch, and the data in the first clock after it ends. The command takes effect at the end of the stretch.
- R2: `dq_oe` is high in a clock only when chip-enable and output-enable were both sampled low at the previous clock edge. Otherwise it is low.
- R3: Byte program is four writes: AAh at 5555h, then 55h at 2AAAh, then A0h at 5555h, then the target address with its data. Unlock addresses are compared on address bits 14:0.
- R4: A write that does not match the expected step returns the decoder to idle. The one exception is a mismatching write of AAh at 5555h, which is taken as the first unlock step.
- R5: Program stores the bitwise AND of the new data and the existing byte, so bits can only go from 1 to 0.
- R6: Sector erase is AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then 30h at any address in the sector. The sector is chosen by address bits 16:12. The erase sets every byte of that sector to FFh and leaves the other sectors untouched.
- R7: Chip erase uses the same first five writes, then 10h at 5555h. It sets every byte to FFh.
- R8: A program stays busy for PROG_CYCLES clocks and an erase for ERASE_CYCLES clocks. Every write that ends while the block is busy is ignored, including complete command sequences.
- R9: A read while busy returns a status byte. Bit 7 is the inverse of bit 7 of the byte being written (FFh for an erase, so bit 7 reads 0), and bits 5:0 read 0.
- R10: Status bit 6 reads 0 on the first read after a launch and flips at the end of every read made while busy.
- R11: After completion, reads return the stored byte, and bit 6 stays stable over repeated reads.
- R12: After reset the array holds FFh everywhere, the decoder is idle, nothing is busy and `dq_oe` is low.
- R13: The array stores 2^SEC_IDX_W sectors of 2^OFF_W bytes. The location index is the low SEC_IDX_W bits of address field 16:12 followed by the low OFF_W address bits. Addresses that share an index alias one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data bus |
| dq_out | output | 8 | Read data or busy status |
| dq_oe | output | 1 | Output driver enable; low means high impedance |

## Verification
Two events can fall in the same clock: a read sampling the bus, and the clock edge at which the internal operation retires and the array takes its new value. The bench provokes this by repeating the same program and sliding the start of the following read across the last busy clocks. A read two clocks before completion must return the status byte, and a read one clock after completion must return the stored byte. The two reads at the boundary must return exactly one of those two values and never a mixture of them. A second overlap is tested by writing a full program sequence while an erase is still running. It is judged by reading back the erased value at the target address.

// File: rtl/fc_pkg.sv
package fc_pkg;
  typedef enum logic [2:0] {
    D_IDLE, D_U1, D_U2, D_PRG, D_E3, D_E4, D_E5
  } dec_st_t;

  typedef enum logic [1:0] {
    OP_PROG, OP_SERASE, OP_CERASE
  } op_t;

  localparam int          KEY_AW    = 15;
  localparam logic [14:0] KEY_ADR_A = 15'h5555;
  localparam logic [14:0] KEY_ADR_B = 15'h2AAA;
  localparam logic [7:0]  KEY_DAT_A = 8'hAA;
  localparam logic [7:0]  KEY_DAT_B = 8'h55;
  localparam logic [7:0]  CMD_PROG  = 8'hA0;
  localparam logic [7:0]  CMD_ERASE = 8'h80;
  localparam logic [7:0]  CMD_SECT  = 8'h30;
  localparam logic [7:0]  CMD_CHIP  = 8'h10;
endpackage

// File: rtl/fc_bus_sampler.sv
module fc_bus_sampler #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic              wr_end,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              rd_act,
  output logic              rd_end,
  output logic [ADDR_W-1:0] rd_addr
);
  logic              s_ce, s_oe, s_we;
  logic [ADDR_W-1:0] s_addr;
  logic [7:0]        s_din;
  logic              wr_q, rd_q;
  logic [ADDR_W-1:0] lat_addr;
  logic              wr_act;

  // one register stage on every pin
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_ce   <= 1'b1;
      s_oe   <= 1'b1;
      s_we   <= 1'b1;
      s_addr <= '0;
      s_din  <= '0;
    end else begin
      s_ce   <= ce_n;
      s_oe   <= oe_n;
      s_we   <= we_n;
      s_addr <= addr;
      s_din  <= din;
    end
  end

  assign wr_act = ~s_ce & ~s_we & s_oe;
  assign rd_act = ~s_ce & ~s_oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q     <= 1'b0;
      rd_q     <= 1'b0;
      lat_addr <= '0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act;
      // address taken when the later strobe has fallen
      if (wr_act && !wr_q) lat_addr <= s_addr;
    end
  end

  // data taken when the first strobe rises
  assign wr_end  = wr_q & ~wr_act;
  assign wr_addr = lat_addr;
  assign wr_data = s_din;
  assign rd_end  = rd_q & ~rd_act;
  assign rd_addr = s_addr;
endmodule

// File: rtl/fc_cmd_decoder.sv
module fc_cmd_decoder
  import fc_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_end,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              busy,
  output logic              start,
  output op_t               op,
  output logic [ADDR_W-1:0] op_addr,
  output logic [7:0]        op_data,
  output logic              idle
);
  dec_st_t st, st_nx;
  logic    go_nx;
  op_t     op_nx;
  logic    hit_a, hit_b, at_a, accept;

  assign at_a   = (wr_addr[KEY_AW-1:0] == KEY_ADR_A);
  assign hit_a  = at_a && (wr_data == KEY_DAT_A);
  assign hit_b  = (wr_addr[KEY_AW-1:0] == KEY_ADR_B) && (wr_data == KEY_DAT_B);
  // a write is dropped while an operation runs or is being launched
  assign accept = wr_end && !busy && !start;

  always_comb begin
    st_nx = st;
    go_nx = 1'b0;
    op_nx = OP_PROG;
    if (accept) begin
      st_nx = hit_a ? D_U1 : D_IDLE;
      unique case (st)
        D_IDLE: ;
        D_U1:   if (hit_b) st_nx = D_U2;
        D_U2: begin
          if (at_a && wr_data == CMD_PROG)  st_nx = D_PRG;
          if (at_a && wr_data == CMD_ERASE) st_nx = D_E3;
        end
        D_PRG: begin
          st_nx = D_IDLE;
          go_nx = 1'b1;
          op_nx = OP_PROG;
        end
        D_E3:   if (hit_a) st_nx = D_E4;
        D_E4:   if (hit_b) st_nx = D_E5;
        D_E5: begin
          if (wr_data == CMD_SECT) begin
            st_nx = D_IDLE;
            go_nx = 1'b1;
            op_nx = OP_SERASE;
          end else if (at_a && wr_data == CMD_CHIP) begin
            st_nx = D_IDLE;
            go_nx = 1'b1;
            op_nx = OP_CERASE;
          end
        end
        default: st_nx = D_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= D_IDLE;
      start   <= 1'b0;
      op      <= OP_PROG;
      op_addr <= '0;
      op_data <= '0;
    end else begin
      st    <= st_nx;
      start <= go_nx;
      if (go_nx) begin
        op      <= op_nx;
        op_addr <= wr_addr;
        op_data <= (op_nx == OP_PROG) ? wr_data : 8'hFF;
      end
    end
  end

  assign idle = (st == D_IDLE);
endmodule

// File: rtl/fc_op_engine.sv
module fc_op_engine
  import fc_pkg::*;
#(
  parameter int ADDR_W       = 17,
  parameter int SEC_LSB      = 12,
  parameter int SEC_IDX_W    = 2,
  parameter int OFF_W        = 4,
  parameter int PROG_CYCLES  = 16,
  parameter int ERASE_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  op_t               op,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [7:0]        op_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_end,
  output logic              busy,
  output logic              tog,
  output logic [7:0]        rd_data
);
  localparam int IDX_W   = SEC_IDX_W + OFF_W;
  localparam int DEPTH   = 1 << IDX_W;
  localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC) + 1;

  logic [7:0]        mem [DEPTH];
  logic [CNT_W-1:0]  cnt;
  op_t               cur_op;
  logic [ADDR_W-1:0] cur_addr;
  logic [7:0]        cur_data;
  logic [IDX_W-1:0]  cur_idx;
  logic [SEC_IDX_W-1:0] cur_sec;

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return {a[SEC_LSB+SEC_IDX_W-1:SEC_LSB], a[OFF_W-1:0]};
  endfunction

  function automatic logic [SEC_IDX_W-1:0] sec_of(input int i);
    logic [IDX_W-1:0] t;
    t = IDX_W'(i);
    return t[IDX_W-1:OFF_W];
  endfunction

  assign cur_idx = idx_of(cur_addr);
  assign cur_sec = cur_addr[SEC_LSB+SEC_IDX_W-1:SEC_LSB];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      tog      <= 1'b0;
      cnt      <= '0;
      cur_op   <= OP_PROG;
      cur_addr <= '0;
      cur_data <= 8'hFF;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (start && !busy) begin
      busy     <= 1'b1;
      tog      <= 1'b0;
      cnt      <= (op == OP_PROG) ? CNT_W'(PROG_CYCLES - 1) : CNT_W'(ERASE_CYCLES - 1);
      cur_op   <= op;
      cur_addr <= op_addr;
      cur_data <= op_data;
    end else if (busy) begin
      if (rd_end) tog <= ~tog;
      if (cnt == '0) begin
        busy <= 1'b0;
        if (cur_op == OP_PROG) begin
          mem[cur_idx] <= mem[cur_idx] & cur_data;
        end else begin
          for (int i = 0; i < DEPTH; i++) begin
            if (cur_op == OP_CERASE || sec_of(i) == cur_sec) mem[i] <= 8'hFF;
          end
        end
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign rd_data = busy ? {~cur_data[7], tog, 6'b0} : mem[idx_of(rd_addr)];
endmodule

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl
  import fc_pkg::*;
#(
  parameter int ADDR_W       = 17,
  parameter int SEC_IDX_W    = 2,
  parameter int OFF_W        = 4,
  parameter int PROG_CYCLES  = 16,
  parameter int ERASE_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dq_out,
  output logic              dq_oe
);
  localparam int SEC_LSB = 12;

  logic              wr_end, rd_act, rd_end;
  logic [ADDR_W-1:0] wr_addr, rd_addr, op_addr;
  logic [7:0]        wr_data, op_data, rd_data;
  logic              op_start, eng_busy, eng_tog, dec_idle;
  op_t               op_kind;

  fc_bus_sampler #(.ADDR_W(ADDR_W)) u_bus (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .wr_end(wr_end), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_act(rd_act), .rd_end(rd_end), .rd_addr(rd_addr)
  );

  fc_cmd_decoder #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_end(wr_end), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(eng_busy), .start(op_start), .op(op_kind),
    .op_addr(op_addr), .op_data(op_data), .idle(dec_idle)
  );

  fc_op_engine #(
    .ADDR_W(ADDR_W), .SEC_LSB(SEC_LSB), .SEC_IDX_W(SEC_IDX_W), .OFF_W(OFF_W),
    .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
  ) u_eng (
    .clk(clk), .rst_n(rst_n), .start(op_start), .op(op_kind),
    .op_addr(op_addr), .op_data(op_data), .rd_addr(rd_addr), .rd_end(rd_end),
    .busy(eng_busy), .tog(eng_tog), .rd_data(rd_data)
  );

  assign dq_oe  = rd_act;
  assign dq_out = rd_data;
endmodule

// File: rtl/fc_checker.sv
module fc_checker (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic oe_n,
  input logic dq_oe,
  input logic busy,
  input logic start,
  input logic dec_idle,
  input logic tog
);
  // R2: driver enabled only after a sampled read condition
  a_r2_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> $past(!ce_n && !oe_n));

  // R8: no launch while an operation is running
  a_r8_no_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && start));

  // R8: a launched operation lasts more than one clock
  a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy);

  // R8: decoder holds no partial sequence while busy
  a_r8_dec_idle_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> dec_idle);

  // R11: toggle bit frozen while idle
  a_r11_tog_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable(tog));
endmodule

bind nor_cmd_ctrl fc_checker i_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .dq_oe(dq_oe),
  .busy(eng_busy), .start(op_start), .dec_idle(dec_idle), .tog(eng_tog)
);

// File: tb/test_nor_cmd_ctrl.sv
module test_nor_cmd_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int PROG_CYC   = 16;
  localparam int ERASE_CYC  = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [16:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dq_out;
  logic        dq_oe;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    logic [7:0] exp;
    logic [7:0] alt;
    string      tag;
  } item_t;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  nor_cmd_ctrl #(.PROG_CYCLES(PROG_CYC), .ERASE_CYCLES(ERASE_CYC)) i_nor_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // monitor: first driven clock of each read pops one expected item
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (dq_oe && !oe_prev) begin
        n_chk++;
        if (sb.size() == 0) begin
          n_fail++;
          $display("FAIL unexpected read: got %02h expected none", dq_out);
        end else begin
          item_t it;
          it = sb.pop_front();
          if (dq_out !== it.exp && dq_out !== it.alt) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h (or %02h)", it.tag, dq_out, it.exp, it.alt);
          end
        end
      end
      oe_prev <= dq_oe;
    end
  end

  task automatic bus_write(input logic [16:0] a, input logic [7:0] d);
    addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
    repeat (2) @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // address valid only at the falling strobe, data only at the rise (R1)
  task automatic skew_write(input logic [16:0] a, input logic [16:0] junk, input logic [7:0] d);
    addr = a; din = 8'h00; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    addr = junk; din = d;
    @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic bus_read(input logic [16:0] a, input logic [7:0] exp,
                          input logic [7:0] alt, input string tag);
    item_t it;
    it.exp = exp; it.alt = alt; it.tag = tag;
    sb.push_back(it);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    repeat (3) @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic unlock3(input logic [7:0] cmd);
    bus_write(17'h05555, 8'hAA);
    bus_write(17'h02AAA, 8'h55);
    bus_write(17'h05555, cmd);
  endtask

  task automatic program_byte(input logic [16:0] a, input logic [7:0] d);
    unlock3(8'hA0);
    bus_write(a, d);
  endtask

  task automatic erase_seq(input logic [16:0] a, input logic [7:0] cmd);
    unlock3(8'h80);
    bus_write(17'h05555, 8'hAA);
    bus_write(17'h02AAA, 8'h55);
    bus_write(a, cmd);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check({7'b0, dq_oe}, 8'h00, "R12 driver off in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({7'b0, dq_oe}, 8'h00, "R12 driver off after reset");
    bus_read(17'h00000, 8'hFF, 8'hFF, "R12 erased after reset");
    bus_read(17'h00025, 8'hFF, 8'hFF, "R12 erased after reset");

    // R2: one strobe alone never drives the bus
    ce_n = 1'b0; repeat (3) @(negedge clk);
    check({7'b0, dq_oe}, 8'h00, "R2 ce only");
    ce_n = 1'b1; oe_n = 1'b0; repeat (3) @(negedge clk);
    check({7'b0, dq_oe}, 8'h00, "R2 oe only");
    oe_n = 1'b1; repeat (2) @(negedge clk);

    // R3 program, R9/R10 status while busy
    program_byte(17'h00003, 8'hA5);
    bus_read(17'h00003, 8'h00, 8'h00, "R9 dq7 inverted first read");
    bus_read(17'h00003, 8'h40, 8'h40, "R10 dq6 flips second read");
    repeat (PROG_CYC + 6) @(negedge clk);
    bus_read(17'h00003, 8'hA5, 8'hA5, "R3 programmed byte");
    bus_read(17'h00003, 8'hA5, 8'hA5, "R11 stable after completion");

    // R5 AND into existing byte
    program_byte(17'h00003, 8'h0F);
    bus_read(17'h00003, 8'h80, 8'h80, "R9 dq7 for bit7 zero");
    repeat (PROG_CYC + 6) @(negedge clk);
    bus_read(17'h00003, 8'h05, 8'h05, "R5 only clears bits");

    // R4 broken sequence then restart by repeated first key
    bus_write(17'h05555, 8'hAA);
    bus_write(17'h01234, 8'h55);
    bus_write(17'h05555, 8'hA0);
    bus_write(17'h00003, 8'h00);
    repeat (PROG_CYC + 6) @(negedge clk);
    bus_read(17'h00003, 8'h05, 8'h05, "R4 mismatch returns to idle");
    bus_write(17'h05555, 8'hAA);
    program_byte(17'h00004, 8'h01);
    repeat (PROG_CYC + 6) @(negedge clk);
    bus_read(17'h00004, 8'h01, 8'h01, "R4 repeated first key restarts");

    // R1 address at falling strobe, data at rising strobe
    unlock3(8'hA0);
    skew_write(17'h00007, 17'h00008, 8'h3E);
    repeat (PROG_CYC + 6) @(negedge clk);
    bus_read(17'h00007, 8'h3E, 8'h3E, "R1 captured address and data");
    bus_read(17'h00008, 8'hFF, 8'hFF, "R1 late address ignored");

    // R8 boundary sweep: read start slides over completion
    for (int w = PROG_CYC - 2; w <= PROG_CYC + 1; w++) begin
      program_byte(17'h00003, 8'h05);
      repeat (w) @(negedge clk);
      if (w == PROG_CYC - 2)
        bus_read(17'h00003, 8'h80, 8'h80, "R8 still busy before end");
      else if (w == PROG_CYC + 1)
        bus_read(17'h00003, 8'h05, 8'h05, "R8 done after end");
      else
        bus_read(17'h00003, 8'h80, 8'h05, "R8 boundary read");
      repeat (PROG_CYC + 4) @(negedge clk);
    end

    // R6 sector erase of sector 1 leaves others
    program_byte(17'h01002, 8'h3C);
    repeat (PROG_CYC + 6) @(negedge clk);
    program_byte(17'h02007, 8'h77);
    repeat (PROG_CYC + 6) @(negedge clk);
    bus_read(17'h01002, 8'h3C, 8'h3C, "R6 sector 1 before erase");
    erase_seq(17'h01FFF, 8'h30);
    bus_read(17'h01002, 8'h00, 8'h00, "R9 erase status dq7 low");
    repeat (ERASE_CYC + 6) @(negedge clk);
    bus_read(17'h01002, 8'hFF, 8'hFF, "R6 sector erased");
    bus_read(17'h02007, 8'h77, 8'h77, "R6 other sector kept");
    bus_read(17'h00003, 8'h05, 8'h05, "R6 sector 0 kept");

    // R13 aliasing of upper sector bits
    program_byte(17'h15003, 8'hC3);
    repeat (PROG_CYC + 6) @(negedge clk);
    bus_read(17'h01003, 8'hC3, 8'hC3, "R13 alias location");

    // R8 writes ignored during an erase
    erase_seq(17'h02000, 8'h30);
    program_byte(17'h02009, 8'h22);
    repeat (ERASE_CYC + 6) @(negedge clk);
    bus_read(17'h02009, 8'hFF, 8'hFF, "R8 program during busy ignored");
    bus_read(17'h02007, 8'hFF, 8'hFF, "R6 sector 2 erased");

    // R7 chip erase
    erase_seq(17'h05555, 8'h10);
    bus_read(17'h00003, 8'h00, 8'h00, "R7 chip erase status");
    bus_read(17'h00003, 8'h40, 8'h40, "R10 toggle during chip erase");
    repeat (ERASE_CYC + 6) @(negedge clk);
    bus_read(17'h00003, 8'hFF, 8'hFF, "R7 sector 0 erased");
    bus_read(17'h01003, 8'hFF, 8'hFF, "R7 sector 1 erased");
    bus_read(17'h00004, 8'hFF, 8'hFF, "R11 normal data after erase");

    repeat (4) @(negedge clk);
    n_chk++;
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: got %0d pending expected 0", sb.size());
    end
    finish_run();
  end
endmodule